// File: doc/BRIEF.md
# Byte Table Lookup Permute Unit

This block assembles a 32-bit result one byte at a time from a small lookup table. The table is a bank of up to four 64-bit registers, so it holds 8 to 32 bytes, and it arrives packed on a single input bus. An index word carries four 8-bit indices, one per lane. Each index picks one table byte, and that byte lands in the same lane of the result.

When a lane's index falls outside the active part of the table, that lane takes the byte at the same position of a caller-supplied default word. A 3-bit count says how many table registers are active, and that count sets the length limit used for the range test.

A transfer is accepted in any cycle where `in_valid` is high. The result is registered and appears on the next clock edge together with `out_valid`. Reset is synchronous and active low.

Top module: `byte_lookup_permute`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is `out_valid` = 0 and `out_word` = 0.
- R2: `out_valid` in cycle n+1 equals `in_valid` in cycle n.
- R3: When `in_valid` is low, `out_word` holds its previous value on the next edge, whatever the data inputs carry.
- R4: A lane whose unsigned index is strictly below the length limit outputs the selected table byte. Lane k occupies bits [8k+7:8k] of both `idx_word` and `out_word`.
- R5: Within a valid index, bits [4:3] (the value of bits [7:3]) select table register r, which occupies `tbl_data[64r+63:64r]`. Bits [2:0] select the byte within that register, and byte 0 is the least significant byte.
- R6: A lane whose index is at or above the limit outputs bits [8k+7:8k] of `dflt_word`.
- R7: When `tbl_regs` is 1, 2, 3 or 4, the length limit is 8 × `tbl_regs`. For codes 0, 5, 6 and 7 the limit is 32.
- R8: An index of 32 or more is out of range under every `tbl_regs` setting.
- R9: Each lane is resolved independently of the indices in the other lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Capture the inputs this cycle |
| idx_word | input | 32 | Four lane indices |
| dflt_word | input | 32 | Fallback bytes for out-of-range lanes |
| tbl_data | input | 256 | Four packed 64-bit table registers |
| tbl_regs | input | 3 | Number of active table registers |
| out_valid | output | 1 | Result valid |
| out_word | output | 32 | Registered result |

## Verification
On every cycle, the assertions check the valid pipeline and the hold-when-idle rule, and that the limit decoder only ever produces a whole number of registers up to the table size. In each lane they also check that an index of 32 or more never counts as a hit, and that a miss always yields the default byte. Which table byte a hit selects, and whether the limit matches the register count, can only be shown by the bench. It sweeps every index value through every lane under all eight count codes against its own arithmetic model of the table addressing.

// File: rtl/bltp_pkg.sv
package bltp_pkg;

  localparam int unsigned BYTE_BITS = 8;

  // Length limit in bytes for a given active-register count.
  // Counts outside 1..max_regs select the whole table.
  function automatic int unsigned limit_of(input int unsigned cnt,
                                           input int unsigned max_regs,
                                           input int unsigned reg_bytes);
    if (cnt >= 1 && cnt <= max_regs)
      return cnt * reg_bytes;
    return max_regs * reg_bytes;
  endfunction

  // Flat bit offset of table byte number sel.
  function automatic int unsigned byte_offset(input int unsigned sel,
                                              input int unsigned byte_w);
    return sel * byte_w;
  endfunction

endpackage

// File: rtl/bltp_limit.sv
module bltp_limit #(
  parameter int unsigned TBL_REGS  = 4,
  parameter int unsigned REG_BYTES = 8,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned LIM_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reg_count,
  output logic [LIM_W-1:0] limit
);
  import bltp_pkg::*;

  localparam int unsigned TBL_BYTES = TBL_REGS * REG_BYTES;

  always_comb begin
    limit = LIM_W'(limit_of(int'(reg_count), TBL_REGS, REG_BYTES));
  end

  // Limit must always be a whole, nonzero number of registers within the table.
  p_limit_whole_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) && (int'(limit) <= TBL_BYTES) && ((int'(limit) % REG_BYTES) == 0));

endmodule

// File: rtl/bltp_lane.sv
module bltp_lane #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned TBL_BYTES = 32,
  parameter int unsigned LIM_W     = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [BYTE_W-1:0]           idx,
  input  logic [BYTE_W-1:0]           dflt,
  input  logic [TBL_BYTES*BYTE_W-1:0] tbl,
  input  logic [LIM_W-1:0]            limit,
  output logic [BYTE_W-1:0]           lane_byte,
  output logic                        lane_hit
);
  import bltp_pkg::*;

  localparam int unsigned SEL_W = $clog2(TBL_BYTES);
  localparam int unsigned CMP_W = BYTE_W + LIM_W;

  logic [CMP_W-1:0]  idx_ext;
  logic [CMP_W-1:0]  lim_ext;
  logic [SEL_W-1:0]  sel;
  logic [BYTE_W-1:0] picked;

  assign idx_ext  = {{LIM_W{1'b0}}, idx};
  assign lim_ext  = {{BYTE_W{1'b0}}, limit};
  assign lane_hit = (idx_ext < lim_ext);
  assign sel      = idx[SEL_W-1:0];

  always_comb begin
    picked = tbl[byte_offset(int'(sel), BYTE_W) +: BYTE_W];
  end

  assign lane_byte = lane_hit ? picked : dflt;

  // Indices beyond the physical table never hit, whatever the limit.
  p_high_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(idx) >= TBL_BYTES) |-> !lane_hit);

  // A missing lane carries the default byte.
  p_miss_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_hit |-> (lane_byte == dflt));

endmodule

// File: rtl/byte_lookup_permute.sv
module byte_lookup_permute #(
  parameter int unsigned LANES     = 4,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned TBL_REGS  = 4,
  parameter int unsigned REG_BYTES = 8,
  localparam int unsigned WORD_W    = LANES * BYTE_W,
  localparam int unsigned TBL_BYTES = TBL_REGS * REG_BYTES,
  localparam int unsigned TBL_W     = TBL_BYTES * BYTE_W,
  localparam int unsigned CNT_W     = $clog2(TBL_REGS) + 1,
  localparam int unsigned LIM_W     = $clog2(TBL_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] idx_word,
  input  logic [WORD_W-1:0] dflt_word,
  input  logic [TBL_W-1:0]  tbl_data,
  input  logic [CNT_W-1:0]  tbl_regs,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);

  logic [LIM_W-1:0]  limit;
  logic [WORD_W-1:0] next_word;
  logic [LANES-1:0]  lane_hits;

  bltp_limit #(
    .TBL_REGS (TBL_REGS),
    .REG_BYTES(REG_BYTES),
    .CNT_W    (CNT_W),
    .LIM_W    (LIM_W)
  ) u_limit (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_count(tbl_regs),
    .limit    (limit)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bltp_lane #(
      .BYTE_W   (BYTE_W),
      .TBL_BYTES(TBL_BYTES),
      .LIM_W    (LIM_W)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (idx_word[k*BYTE_W +: BYTE_W]),
      .dflt     (dflt_word[k*BYTE_W +: BYTE_W]),
      .tbl      (tbl_data),
      .limit    (limit),
      .lane_byte(next_word[k*BYTE_W +: BYTE_W]),
      .lane_hit (lane_hits[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid)
        out_word <= next_word;
    end
  end

  // Valid pipeline: one cycle, both polarities.
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // Idle cycles leave the result untouched.
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word));

endmodule

// File: tb/sim_byte_lookup_permute.sv
module sim_byte_lookup_permute;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  idx_word;
  logic [31:0]  dflt_word;
  logic [255:0] tbl_data;
  logic [2:0]   tbl_regs;
  logic         out_valid;
  logic [31:0]  out_word;

  int  n_checks = 0;
  int  n_fails  = 0;
  int  cycles   = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  byte_lookup_permute u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .idx_word (idx_word),
    .dflt_word(dflt_word),
    .tbl_data (tbl_data),
    .tbl_regs (tbl_regs),
    .out_valid(out_valid),
    .out_word (out_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  function automatic int ref_limit(input logic [2:0] code);
    if (code >= 3'd1 && code <= 3'd4) return 8 * int'(code);
    return 32;
  endfunction

  function automatic logic [7:0] ref_byte(input logic [255:0] t, input int i);
    int r, b;
    logic [63:0] reg_word;
    r = i / 8;
    b = i % 8;
    reg_word = t[r*64 +: 64];
    return reg_word[b*8 +: 8];
  endfunction

  task automatic run_one(input logic [31:0] iw, input logic [31:0] dw, input logic [2:0] cnt);
    logic [31:0] hold;
    @(negedge clk);
    idx_word = iw; dflt_word = dw; tbl_regs = cnt; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {31'd0, out_valid}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      int i;
      logic [7:0] exp;
      string req;
      i = int'(iw[k*8 +: 8]);
      if (i < ref_limit(cnt)) begin
        exp = ref_byte(tbl_data, i);
        req = "R4";
      end else begin
        exp = dw[k*8 +: 8];
        req = (i >= 32) ? "R8" : "R6";
      end
      if (!(cnt >= 3'd1 && cnt <= 3'd4) && i < 32) req = "R7";
      check(req, {24'd0, out_word[k*8 +: 8]}, {24'd0, exp});
    end
    hold = out_word;
    // Scramble inputs while idle: result must not move.
    idx_word = ~iw; dflt_word = ~dw;
    @(negedge clk);
    check("R2", {31'd0, out_valid}, 32'd0);
    check("R3", out_word, hold);
  endtask

  initial begin
    logic [31:0] iw;
    rst_n = 1'b0; in_valid = 1'b1; idx_word = 32'h0302_0100;
    dflt_word = 32'hFFFF_FFFF; tbl_regs = 3'd4;
    tbl_data = {8{32'hDEAD_BEEF}};
    repeat (3) @(negedge clk);
    check("R1", {31'd0, out_valid}, 32'd0);
    check("R1", out_word, 32'd0);
    rst_n = 1'b1; in_valid = 1'b0;
    @(negedge clk);

    // R5: each table byte holds its own flat number plus a register tag.
    for (int n = 0; n < 32; n++) tbl_data[n*8 +: 8] = 8'((n / 8) * 8'h40 + n);
    for (int n = 0; n < 32; n += 4) begin
      iw = {8'(n + 3), 8'(n + 2), 8'(n + 1), 8'(n)};
      run_one(iw, 32'hA5A5_A5A5, 3'd4);
      check("R5", out_word,
            {ref_byte(tbl_data, n + 3), ref_byte(tbl_data, n + 2),
             ref_byte(tbl_data, n + 1), ref_byte(tbl_data, n)});
    end

    // Sweep every count code and every index value in every lane (R9: lanes
    // receive unrelated indices in the same transfer).
    for (int c = 0; c < 8; c++) begin
      for (int v = 0; v < 256; v++) begin
        if (v % 32 == 0)
          for (int w = 0; w < 8; w++) tbl_data[w*32 +: 32] = $urandom;
        iw = {8'(v ^ 8'hA5), 8'(v * 7), 8'(v + 1), 8'(v)};
        run_one(iw, $urandom, 3'(c));
      end
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule